// File: doc/BRIEF.md
# Scanline Sprite Line Renderer

This block builds the sprite layer of one display line. A start pulse brings in the line number and two control bits. The block then walks the object table, which has 40 four-byte slots, in slot order. For each slot that covers the line, it fetches the two bitplane bytes of the matching tile row. It writes the non-transparent 2-bit colour indices of that row into a 160-column line buffer. Both the object table and the tile store are external memories with synchronous reads. Each read returns its data on the cycle after the address is presented.

The surrounding display pipeline clears or pre-fills the line buffer, pulses the start input, and waits for the done flag. The done flag tells it that every sprite pixel for that line has been written. Palette lookup, background drawing and display timing are handled outside this block.

Top module: `spr_line_render`

## Requirements
- R1: After reset, `done` is low and `lb_we` is low until the first `line_start` pulse.
- R2: Each table slot `s` holds four bytes at addresses 4s..4s+3:
  - vertical position at 4s;
  - horizontal position at 4s+1;
  - tile index at 4s+2;
  - flags at 4s+3, which are not used.
  A slot whose vertical or horizontal byte is zero produces no pixels and does not count towards the per-line limit.
- R3: The sprite's top row is at (vertical byte − 16). Its leftmost column is at (horizontal byte − 8). Pixel k of a row (k = 0..7) goes to column (horizontal byte − 8 + k).
- R4: With `tall_mode` = 0 a sprite is 8 rows high; with `tall_mode` = 1 it is 16 rows high. Row r of a sprite (r = line + 16 − vertical byte) reads tile bytes at (tile·16 + 2r) mod 4096 and the byte after it. In tall mode, rows 8..15 therefore run on into the next tile.
- R5: For pixel k, bit (7 − k) of the even-addressed byte forms bit 0 of the colour index. The same bit of the odd-addressed byte forms bit 1.
- R6: A colour index of 0 is transparent and is never written to the line buffer.
- R7: When `spr_enable` is 0 at `line_start`, nothing is written for that line and `done` still rises.
- R8: At most 10 covering slots are drawn per line, taken in ascending slot order; later covering slots are ignored. Where drawn sprites overlap, the higher-numbered slot's pixel is written last and remains.
- R9: Pixels whose column falls outside 0..159 are discarded, and `lb_addr` is always below 160 when `lb_we` is high.
- R10: `done` rises once all writes for the line are finished. It stays high until the next `line_start`, and no write occurs while it is high. `line_start` is accepted only while the block is idle or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_start | input | 1 | One-cycle pulse that begins a line |
| line_num | input | 8 | Line number, sampled with `line_start` |
| spr_enable | input | 1 | Sprite layer enable, sampled with `line_start` |
| tall_mode | input | 1 | 8x16 sprite mode, sampled with `line_start` |
| oam_re | output | 1 | Object table read enable |
| oam_addr | output | 8 | Object table byte address |
| oam_rdata | input | 8 | Object table data, valid the cycle after the read |
| tile_re | output | 1 | Tile store read enable |
| tile_addr | output | 12 | Tile store byte address |
| tile_rdata | input | 8 | Tile store data, valid the cycle after the read |
| lb_we | output | 1 | Line buffer write strobe |
| lb_addr | output | 8 | Line buffer column |
| lb_data | output | 2 | Colour index written |
| done | output | 1 | Line finished |

## Verification
The hardest case to reach from the ports is a line where the ten-sprite cut-off coincides with other edge conditions:
- hidden slots that must not consume a place in the limit;
- sprites clipped at the left or right edge;
- overlapping sprites where the write order decides the final pixel.

A directed table stacks fourteen slots on the same rows and places hidden entries and edge positions among them. The bench then sweeps the lines across that band in both height modes. Pseudo-random tables then cover many further lines. Each line's buffer contents and per-column write flags are compared with a model computed in the bench.

// File: rtl/spr_line_pkg.sv
// Shared types for the sprite line renderer.
// Assumes one table slot is processed at a time by a single controller.
package spr_line_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_Y,
        ST_RD_X,
        ST_RD_T,
        ST_EVAL,
        ST_F_LO,
        ST_F_HI,
        ST_CAP_HI,
        ST_PIX,
        ST_DONE
    } rstate_t;

    typedef struct packed {
        logic [7:0] ypos;
        logic [7:0] xpos;
        logic [7:0] tile;
    } slot_t;

endpackage

// File: rtl/spr_hit_eval.sv
// Decides whether a table slot covers the current line and which tile row
// it contributes. Purely combinational.
// Assumes the vertical offset is 16 and heights fit in 4 row bits.
module spr_hit_eval #(
    parameter int Y_OFS   = 16,
    parameter int SMALL_H = 8
) (
    input  logic [7:0] line_num,
    input  logic [7:0] ypos,
    input  logic [7:0] xpos,
    input  logic       tall,
    output logic       hit,
    output logic [3:0] row
);
    localparam int TALL_H = 2 * SMALL_H;

    logic [9:0] diff;
    logic [9:0] height;

    // Row offset from the sprite top, with wrap-around for lines above it.
    always_comb begin
        diff   = {2'b00, line_num} + 10'(Y_OFS) - {2'b00, ypos};
        height = tall ? 10'(TALL_H) : 10'(SMALL_H);
        hit    = (ypos != 8'd0) && (xpos != 8'd0) && (diff < height);
        row    = diff[3:0];
    end
endmodule

// File: rtl/spr_pixel_emit.sv
// Produces the line-buffer write for pixel k of the current sprite row:
// selects the plane bits MSB first, suppresses transparent pixels and
// clips columns outside the visible line.
module spr_pixel_emit #(
    parameter int X_OFS  = 8,
    parameter int LINE_W = 160
) (
    input  logic       active,
    input  logic [7:0] xpos,
    input  logic [2:0] k,
    input  logic [7:0] plane_lo,
    input  logic [7:0] plane_hi,
    output logic       we,
    output logic [7:0] addr,
    output logic [1:0] color
);
    logic [8:0] col;
    logic [2:0] bsel;
    logic       in_line;

    // Column position, bit select and visibility of this pixel.
    always_comb begin
        bsel    = 3'd7 - k;
        col     = {1'b0, xpos} + {6'b0, k};
        color   = {plane_hi[bsel], plane_lo[bsel]};
        in_line = (col >= 9'(X_OFS)) && (col < 9'(X_OFS + LINE_W));
        addr    = 8'(col - 9'(X_OFS));
        we      = active && in_line && (color != 2'b00);
    end
endmodule

// File: rtl/spr_line_render.sv
// Sprite line renderer top. On line_start it scans the object table in
// slot order using three synchronous reads per slot. For each covering slot
// it reads two plane bytes and emits eight pixels, one per cycle. It stops
// after MAX_PER_LINE covering slots or at the last slot, then holds done.
// Assumes both memories return data one cycle after the address.
module spr_line_render
    import spr_line_pkg::*;
#(
    parameter int N_SLOTS      = 40,
    parameter int MAX_PER_LINE = 10,
    parameter int LINE_W       = 160,
    parameter int X_OFS        = 8,
    parameter int Y_OFS        = 16,
    parameter int SMALL_H      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        line_start,
    input  logic [7:0]  line_num,
    input  logic        spr_enable,
    input  logic        tall_mode,
    output logic        oam_re,
    output logic [7:0]  oam_addr,
    input  logic [7:0]  oam_rdata,
    output logic        tile_re,
    output logic [11:0] tile_addr,
    input  logic [7:0]  tile_rdata,
    output logic        lb_we,
    output logic [7:0]  lb_addr,
    output logic [1:0]  lb_data,
    output logic        done
);
    localparam int IDX_W = $clog2(N_SLOTS);
    localparam int CNT_W = $clog2(MAX_PER_LINE + 1);

    rstate_t            state;
    logic [IDX_W-1:0]   idx;
    logic [CNT_W-1:0]   cnt;
    slot_t              slot_q;
    logic [3:0]         row_q;
    logic [7:0]         lo_q;
    logic [7:0]         hi_q;
    logic [2:0]         pix_k;
    logic [7:0]         line_q;
    logic               tall_q;
    logic               hit;
    logic [3:0]         hit_row;
    logic               last_slot;
    logic               cap_full;
    logic [11:0]        row_base;

    spr_hit_eval #(
        .Y_OFS   (Y_OFS),
        .SMALL_H (SMALL_H)
    ) hit_i (
        .line_num (line_q),
        .ypos     (slot_q.ypos),
        .xpos     (slot_q.xpos),
        .tall     (tall_q),
        .hit      (hit),
        .row      (hit_row)
    );

    spr_pixel_emit #(
        .X_OFS  (X_OFS),
        .LINE_W (LINE_W)
    ) pix_i (
        .active   (state == ST_PIX),
        .xpos     (slot_q.xpos),
        .k        (pix_k),
        .plane_lo (lo_q),
        .plane_hi (hi_q),
        .we       (lb_we),
        .addr     (lb_addr),
        .color    (lb_data)
    );

    // End-of-scan conditions for the slot in progress.
    always_comb begin
        last_slot = (idx == IDX_W'(N_SLOTS - 1));
        cap_full  = (cnt == CNT_W'(MAX_PER_LINE));
        row_base  = {slot_q.tile, 4'b0000} + {7'b0, row_q, 1'b0};
    end

    // Memory read addresses and enables driven from the current state.
    always_comb begin
        oam_re    = 1'b0;
        oam_addr  = {idx, 2'b00};
        tile_re   = 1'b0;
        tile_addr = row_base;
        case (state)
            ST_RD_Y: oam_re = 1'b1;
            ST_RD_X: begin
                oam_re   = 1'b1;
                oam_addr = {idx, 2'b01};
            end
            ST_RD_T: begin
                oam_re   = 1'b1;
                oam_addr = {idx, 2'b10};
            end
            ST_F_LO: tile_re = 1'b1;
            ST_F_HI: begin
                tile_re   = 1'b1;
                tile_addr = row_base + 12'd1;
            end
            default: ;
        endcase
        done = (state == ST_DONE);
    end

    // Line control state machine with slot, count and pixel bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            cnt    <= '0;
            slot_q <= '0;
            row_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            pix_k  <= '0;
            line_q <= '0;
            tall_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (line_start) begin
                        line_q <= line_num;
                        tall_q <= tall_mode;
                        idx    <= '0;
                        cnt    <= '0;
                        state  <= spr_enable ? ST_RD_Y : ST_DONE;
                    end
                end
                ST_RD_Y: state <= ST_RD_X;
                ST_RD_X: begin
                    slot_q.ypos <= oam_rdata;
                    state       <= ST_RD_T;
                end
                ST_RD_T: begin
                    slot_q.xpos <= oam_rdata;
                    state       <= ST_EVAL;
                end
                ST_EVAL: begin
                    slot_q.tile <= oam_rdata;
                    if (hit) begin
                        row_q <= hit_row;
                        cnt   <= cnt + CNT_W'(1);
                        state <= ST_F_LO;
                    end else if (last_slot) begin
                        state <= ST_DONE;
                    end else begin
                        idx   <= idx + IDX_W'(1);
                        state <= ST_RD_Y;
                    end
                end
                ST_F_LO: state <= ST_F_HI;
                ST_F_HI: begin
                    lo_q  <= tile_rdata;
                    state <= ST_CAP_HI;
                end
                ST_CAP_HI: begin
                    hi_q  <= tile_rdata;
                    pix_k <= '0;
                    state <= ST_PIX;
                end
                ST_PIX: begin
                    pix_k <= pix_k + 3'd1;
                    if (pix_k == 3'd7) begin
                        if (last_slot || cap_full) begin
                            state <= ST_DONE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= ST_RD_Y;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/spr_line_render_chk.sv
// Port-level checker for the sprite line renderer, bound to every instance.
module spr_line_render_chk #(
    parameter int MAX_PER_LINE = 10,
    parameter int LINE_W       = 160
) (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       spr_enable,
    input logic       tile_re,
    input logic       lb_we,
    input logic [7:0] lb_addr,
    input logic [1:0] lb_data,
    input logic       done
);
    logic       quiet_line;
    logic [7:0] fetch_cnt;

    // Tracks disabled lines and counts tile reads within the current line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_line <= 1'b0;
            fetch_cnt  <= '0;
        end else if (line_start && (done || fetch_cnt == 8'd0)) begin
            quiet_line <= !spr_enable;
            fetch_cnt  <= '0;
        end else if (tile_re && fetch_cnt != 8'hFF) begin
            fetch_cnt <= fetch_cnt + 8'd1;
        end
    end

    a_r9_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> (lb_addr < 8'(LINE_W)));

    a_r6_no_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> (lb_data != 2'b00));

    a_r10_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !line_start) |=> done);

    a_r10_no_write_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !lb_we);

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_line |-> (!lb_we && !tile_re));

    a_r8_fetch_limit: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cnt <= 8'(2 * MAX_PER_LINE));
endmodule

bind spr_line_render spr_line_render_chk #(
    .MAX_PER_LINE (MAX_PER_LINE),
    .LINE_W       (LINE_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .spr_enable (spr_enable),
    .tile_re    (tile_re),
    .lb_we      (lb_we),
    .lb_addr    (lb_addr),
    .lb_data    (lb_data),
    .done       (done)
);

// File: tb/spr_line_render_tb_top.sv
// Self-checking bench: models both memories, sweeps lines over a directed
// table and pseudo-random tables, and compares the whole line buffer.
module spr_line_render_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic [7:0]  line_num = '0;
    logic        spr_enable = 1'b0;
    logic        tall_mode = 1'b0;
    logic        oam_re;
    logic [7:0]  oam_addr;
    logic [7:0]  oam_rdata;
    logic        tile_re;
    logic [11:0] tile_addr;
    logic [7:0]  tile_rdata;
    logic        lb_we;
    logic [7:0]  lb_addr;
    logic [1:0]  lb_data;
    logic        done;

    logic [7:0] oam_mem  [0:159];
    logic [7:0] tile_mem [0:4095];
    logic [1:0] got_col  [0:159];
    logic       got_wr   [0:159];
    int         exp_col  [0:159];
    int         exp_wr   [0:159];
    int         vectors = 0;
    int         errors  = 0;
    int         bad_addr = 0;
    int         cycles = 0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    spr_line_render dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_num   (line_num),
        .spr_enable (spr_enable),
        .tall_mode  (tall_mode),
        .oam_re     (oam_re),
        .oam_addr   (oam_addr),
        .oam_rdata  (oam_rdata),
        .tile_re    (tile_re),
        .tile_addr  (tile_addr),
        .tile_rdata (tile_rdata),
        .lb_we      (lb_we),
        .lb_addr    (lb_addr),
        .lb_data    (lb_data),
        .done       (done)
    );

    // Synchronous-read memory models.
    always @(posedge clk) begin
        if (oam_re)  oam_rdata  <= oam_mem[oam_addr];
        if (tile_re) tile_rdata <= tile_mem[tile_addr];
    end

    // Line buffer capture, sampled away from the active edge.
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && lb_we) begin
            if (lb_addr >= 8'd160) bad_addr <= bad_addr + 1;
            else begin
                got_col[lb_addr] <= lb_data;
                got_wr[lb_addr]  <= 1'b1;
            end
        end
    end

    function automatic logic [31:0] next_rng(input logic [31:0] s);
        logic [31:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 17);
        v = v ^ (v << 5);
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input string what);
        vectors++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    // Reference model of one line (R2..R9).
    task automatic model_line(input int ln, input bit en, input bit tall);
        int cnt;
        cnt = 0;
        for (int c = 0; c < 160; c++) begin
            exp_col[c] = 0;
            exp_wr[c]  = 0;
        end
        if (!en) return;
        for (int s = 0; s < 40; s++) begin
            int y, x, t, d, h, base, lo, hi;
            y = oam_mem[4*s];
            x = oam_mem[4*s+1];
            t = oam_mem[4*s+2];
            if (y == 0 || x == 0) continue;
            d = ln + 16 - y;
            h = tall ? 16 : 8;
            if (d < 0 || d >= h) continue;
            if (cnt == 10) break;
            cnt++;
            base = (t * 16 + d * 2) % 4096;
            lo = tile_mem[base];
            hi = tile_mem[(base + 1) % 4096];
            for (int k = 0; k < 8; k++) begin
                int cv, col;
                cv  = ((lo >> (7 - k)) & 1) | (((hi >> (7 - k)) & 1) << 1);
                col = x - 8 + k;
                if (cv != 0 && col >= 0 && col < 160) begin
                    exp_col[col] = cv;
                    exp_wr[col]  = 1;
                end
            end
        end
    endtask

    task automatic run_line(input int ln, input bit en, input bit tall, input string tag);
        int wait_n;
        for (int c = 0; c < 160; c++) begin
            got_col[c] = 2'b00;
            got_wr[c]  = 1'b0;
        end
        model_line(ln, en, tall);
        @(negedge clk);
        line_num   = 8'(ln);
        spr_enable = en;
        tall_mode  = tall;
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 2000) begin
            @(negedge clk);
            wait_n++;
        end
        check("R10", int'(done), 1, {tag, " done raised"});
        @(negedge clk);
        check("R10", int'(done), 1, {tag, " done held"});
        for (int c = 0; c < 160; c++) begin
            // R6 transparent columns stay unwritten; R5/R8 colour and order.
            check("R6", int'(got_wr[c]), exp_wr[c], $sformatf("%s line %0d col %0d written", tag, ln, c));
            check("R5", int'(got_col[c]), exp_col[c], $sformatf("%s line %0d col %0d colour", tag, ln, c));
        end
        check("R9", bad_addr, 0, "write beyond column 159");
    endtask

    task automatic clear_oam();
        for (int a = 0; a < 160; a++) oam_mem[a] = 8'h00;
    endtask

    // Directed table: 14 slots stacked on one band, hidden entries, edges (R2, R3, R8, R9).
    task automatic load_directed();
        clear_oam();
        for (int s = 0; s < 14; s++) begin
            oam_mem[4*s]   = 8'd56;
            oam_mem[4*s+1] = 8'(1 + s * 12);
            oam_mem[4*s+2] = 8'(s * 3 + 1);
            oam_mem[4*s+3] = 8'hFF;
        end
        oam_mem[4*2+1]  = 8'd0;    // hidden by X
        oam_mem[4*5]    = 8'd0;    // hidden by Y
        oam_mem[4*7+1]  = 8'd4;    // overlaps slot 0, clipped left
        oam_mem[4*9+1]  = 8'd165;  // clipped right
        oam_mem[4*10+1] = 8'd163;  // overlaps slot 9
        oam_mem[4*20]   = 8'd60;   // lone sprite lower, other band
        oam_mem[4*20+1] = 8'd80;
        oam_mem[4*20+2] = 8'd255;  // tall mode wraps to tile 0
    endtask

    task automatic load_random();
        for (int s = 0; s < 40; s++) begin
            rng = next_rng(rng);
            oam_mem[4*s]   = (rng[2:0] == 3'd0) ? 8'd0 : 8'(rng[15:8] % 180);
            rng = next_rng(rng);
            oam_mem[4*s+1] = (rng[3:0] == 4'd0) ? 8'd0 : 8'(rng[15:8] % 176);
            oam_mem[4*s+2] = rng[31:24];
            oam_mem[4*s+3] = rng[23:16];
        end
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) tile_mem[a] = 8'(((a * 29) ^ (a >> 3)) + (a >> 7));
        clear_oam();
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", int'(done), 0, "done after reset");
        check("R1", int'(lb_we), 0, "lb_we during reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(done), 0, "done idle before first line");
        check("R1", int'(lb_we), 0, "lb_we idle before first line");

        // R2 R3 R4 R8 R9: directed band, both heights.
        load_directed();
        for (int ln = 30; ln < 62; ln++) begin
            run_line(ln, 1'b1, 1'b0, "directed short");
            run_line(ln, 1'b1, 1'b1, "directed tall R4");
        end
        // R7: disabled line writes nothing even where sprites cover it.
        run_line(40, 1'b0, 1'b0, "disabled R7");
        run_line(40, 1'b0, 1'b1, "disabled tall R7");

        // Pseudo-random tables.
        for (int p = 0; p < 3; p++) begin
            load_random();
            for (int ln = 0; ln < 144; ln += 4)
                run_line(ln + p, (ln % 28) != 12, ((ln >> 2) % 2) == 1, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: counts as a failed check and still reports.
    initial begin
        #(20 * 190000);
        errors++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule